// File: doc/BRIEF.md
# Rate-Pin Setting Selector

This block resolves which receive-filter bandwidth code and which loss-of-signal threshold code are active in a rate-selectable receive front end. Two asynchronous rate-select pins pick one of four slots. Each slot has one bandwidth override register and one threshold override register. Bit 7 of each override register chooses between a built-in default code for that slot and the code held in the register's low bits. The resolved codes are driven to the analog stages and are also presented as zero-padded status bytes that a register read path can return unchanged.

The same block turns the output-stage control fields into enables that the analog stages can use directly. The amplitude field becomes a one-hot choice among three swing levels. The pre-emphasis field becomes a step count from 0 to 8 and a matching thermometer vector. The output-disable bit and the threshold-range bit are taken from the control byte and registered. Every output is registered. The rate pins first pass through a two-flop synchronizer.

Top module: `pin_setting_mux`

## Requirements
- R1: The slot index is taken from the synchronized pins {rate_hi_pin, rate_lo_pin}. 00 selects slot 0, 01 selects slot 1, 11 selects slot 2 and 10 selects slot 3. Index k of bw_slot_reg and los_slot_reg belongs to slot k.
- R2: While reset is active, the synchronizer holds rate_hi=1 and rate_lo=0. So slot 3 is in use until the real pin values have passed through.
- R3: If bit 7 of the selected bandwidth register is 0, bw_code is that slot's default: 4'b1111, 4'b1000, 4'b0101 and 4'b0010 for slots 0 to 3. If bit 7 is 1, bw_code is bits 3:0 of that register.
- R4: If bit 7 of the selected threshold register is 1, los_code is bits 6:0 of that register. Otherwise los_code is that slot's parameter default: 0, 10, 40 and 40 for slots 0 to 3.
- R5: bw_status equals {4'b0000, bw_code} and los_status equals {1'b0, los_code}.
- R6: A pin change is visible on the outputs after the third rising clock edge. A change on a register input is visible after the first rising edge.
- R7: amp_en is one-hot, decoded from amp_reg[1:0]. 00 sets bit 0 (300 mVpp), 01 and 10 set bit 1 (600 mVpp), and 11 sets bit 2 (900 mVpp).
- R8: pe_reg[3:0] maps to pe_db. The listed codes 0,1,3,4,5,7,12,13,15 give 0 to 8. Any other code takes the value of the nearest lower listed code. pe_therm has its low pe_db bits set.
- R9: out_disable follows ctrl_reg bit 3 and los_high_range follows ctrl_reg bit 2.
- R10: During reset the outputs are: bw_code 4'b0010, los_code 40, amp_en 000, pe_db 0, pe_therm 0, out_disable 0 and los_high_range 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_hi_pin | input | 1 | Upper rate-select pin, asynchronous |
| rate_lo_pin | input | 1 | Lower rate-select pin, asynchronous |
| ctrl_reg | input | 8 | Control byte: bit 3 output disable, bit 2 threshold range |
| amp_reg | input | 8 | Amplitude byte, bits 1:0 used |
| pe_reg | input | 8 | Pre-emphasis byte, bits 3:0 used |
| bw_slot_reg | input | 4x8 | Bandwidth override per slot: bit 7 custom flag, bits 3:0 code |
| los_slot_reg | input | 4x8 | Threshold override per slot: bit 7 custom flag, bits 6:0 code |
| bw_code | output | 4 | Active bandwidth code |
| los_code | output | 7 | Active threshold code |
| bw_status | output | 8 | Read-only byte holding bw_code |
| los_status | output | 8 | Read-only byte holding los_code |
| amp_en | output | 3 | One-hot swing select |
| pe_db | output | 4 | Pre-emphasis step count, 0 to 8 |
| pe_therm | output | 8 | Thermometer form of pe_db |
| out_disable | output | 1 | Output stage disable |
| los_high_range | output | 1 | Threshold range select |

## Verification
The hardest case to reach is a pin transition that lands while the override registers are also changing. In that case the outputs must combine the old slot with the new register contents for two cycles before the new slot applies. The stimulus moves the pins at clock-aligned points and rewrites the custom flags within the following two cycles. The reference model keeps its own history of pin samples, so every intermediate cycle is compared. Pins held at a fixed code across reset, and the round-down pre-emphasis codes, are also driven explicitly.

// File: rtl/pin_setting_mux.sv
module pin_setting_mux #(
  parameter int          BW_W     = 4,
  parameter int          LOS_W    = 7,
  parameter int          REG_W    = 8,
  parameter int          NSLOT    = 4,
  parameter int          PE_MAX   = 8,
  parameter logic [3:0]  BW_DEF0  = 4'b1111,
  parameter logic [3:0]  BW_DEF1  = 4'b1000,
  parameter logic [3:0]  BW_DEF2  = 4'b0101,
  parameter logic [3:0]  BW_DEF3  = 4'b0010,
  parameter logic [6:0]  LOS_DEF0 = 7'd0,
  parameter logic [6:0]  LOS_DEF1 = 7'd10,
  parameter logic [6:0]  LOS_DEF2 = 7'd40,
  parameter logic [6:0]  LOS_DEF3 = 7'd40
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rate_hi_pin,
  input  logic                        rate_lo_pin,
  input  logic [REG_W-1:0]            ctrl_reg,
  input  logic [REG_W-1:0]            amp_reg,
  input  logic [REG_W-1:0]            pe_reg,
  input  logic [NSLOT-1:0][REG_W-1:0] bw_slot_reg,
  input  logic [NSLOT-1:0][REG_W-1:0] los_slot_reg,
  output logic [BW_W-1:0]             bw_code,
  output logic [LOS_W-1:0]            los_code,
  output logic [REG_W-1:0]            bw_status,
  output logic [REG_W-1:0]            los_status,
  output logic [2:0]                  amp_en,
  output logic [3:0]                  pe_db,
  output logic [PE_MAX-1:0]           pe_therm,
  output logic                        out_disable,
  output logic                        los_high_range
);
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int FLAG   = REG_W - 1;
  localparam int DIS_B  = 3;
  localparam int RNG_B  = 2;

  logic [1:0] sync1, sync2;
  logic [SLOT_W-1:0] slot;
  logic [REG_W-1:0] bw_sel_reg, los_sel_reg;
  logic [BW_W-1:0]  bw_dflt, bw_next;
  logic [LOS_W-1:0] los_dflt, los_next;
  logic [2:0] amp_next;
  logic [3:0] pe_next;
  logic [PE_MAX-1:0] therm_next;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= 2'b10;
      sync2 <= 2'b10;
    end else begin
      sync1 <= {rate_hi_pin, rate_lo_pin};
      sync2 <= sync1;
    end

  // Gray-ordered pin code to slot index: 00->0, 01->1, 11->2, 10->3
  assign slot        = {sync2[1], sync2[1] ^ sync2[0]};
  assign bw_sel_reg  = bw_slot_reg[slot];
  assign los_sel_reg = los_slot_reg[slot];

  always_comb begin
    case (slot)
      2'd0:    begin bw_dflt = BW_DEF0; los_dflt = LOS_DEF0; end
      2'd1:    begin bw_dflt = BW_DEF1; los_dflt = LOS_DEF1; end
      2'd2:    begin bw_dflt = BW_DEF2; los_dflt = LOS_DEF2; end
      default: begin bw_dflt = BW_DEF3; los_dflt = LOS_DEF3; end
    endcase
  end

  assign bw_next  = bw_sel_reg[FLAG]  ? bw_sel_reg[BW_W-1:0]   : bw_dflt;
  assign los_next = los_sel_reg[FLAG] ? los_sel_reg[LOS_W-1:0] : los_dflt;

  always_comb begin
    case (amp_reg[1:0])
      2'b00:   amp_next = 3'b001;
      2'b11:   amp_next = 3'b100;
      default: amp_next = 3'b010;
    endcase
  end

  always_comb begin
    case (pe_reg[3:0])
      4'd0:                    pe_next = 4'd0;
      4'd1, 4'd2:              pe_next = 4'd1;
      4'd3:                    pe_next = 4'd2;
      4'd4:                    pe_next = 4'd3;
      4'd5, 4'd6:              pe_next = 4'd4;
      4'd7, 4'd8, 4'd9,
      4'd10, 4'd11:            pe_next = 4'd5;
      4'd12:                   pe_next = 4'd6;
      4'd13, 4'd14:            pe_next = 4'd7;
      default:                 pe_next = 4'd8;
    endcase
  end

  for (genvar i = 0; i < PE_MAX; i++) begin : g_therm
    assign therm_next[i] = (pe_next > 4'(i));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bw_code        <= BW_DEF3;
      los_code       <= LOS_DEF3;
      amp_en         <= '0;
      pe_db          <= '0;
      pe_therm       <= '0;
      out_disable    <= 1'b0;
      los_high_range <= 1'b0;
    end else begin
      bw_code        <= bw_next;
      los_code       <= los_next;
      amp_en         <= amp_next;
      pe_db          <= pe_next;
      pe_therm       <= therm_next;
      out_disable    <= ctrl_reg[DIS_B];
      los_high_range <= ctrl_reg[RNG_B];
    end

  assign bw_status  = {{(REG_W-BW_W){1'b0}}, bw_code};
  assign los_status = {{(REG_W-LOS_W){1'b0}}, los_code};

  assert_ctrl_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_disable == $past(ctrl_reg[DIS_B])) && (los_high_range == $past(ctrl_reg[RNG_B])));

  assert_amp_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(amp_en) == 1);

  assert_amp_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(amp_reg[1:0]) == 2'b11 && $past(rst_n)) |-> amp_en[2]);

  assert_therm_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pe_therm) == 32'(pe_db) && pe_db <= 4'(PE_MAX));

  assert_status_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bw_status[REG_W-1:BW_W] == '0 && los_status[REG_W-1] == 1'b0);
endmodule

// File: tb/test_pin_setting_mux.sv
module test_pin_setting_mux;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi = 1'b1, lo = 1'b0;
  logic [7:0] ctrl = '0, amp = '0, pe = '0;
  logic [3:0][7:0] bwr = '0, losr = '0;
  logic [3:0] bw_code; logic [6:0] los_code;
  logic [7:0] bw_status, los_status;
  logic [2:0] amp_en; logic [3:0] pe_db; logic [7:0] pe_therm;
  logic out_disable, los_high_range;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pin_setting_mux i_pin_setting_mux (
    .clk(clk), .rst_n(rst_n), .rate_hi_pin(hi), .rate_lo_pin(lo),
    .ctrl_reg(ctrl), .amp_reg(amp), .pe_reg(pe),
    .bw_slot_reg(bwr), .los_slot_reg(losr),
    .bw_code(bw_code), .los_code(los_code), .bw_status(bw_status), .los_status(los_status),
    .amp_en(amp_en), .pe_db(pe_db), .pe_therm(pe_therm),
    .out_disable(out_disable), .los_high_range(los_high_range));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int slot_of(input bit h, input bit l);
    if (!h && !l) return 0;
    if (!h && l)  return 1;
    if (h && l)   return 2;
    return 3;
  endfunction

  function automatic int pe_steps(input int code);
    int listed[9] = '{0, 1, 3, 4, 5, 7, 12, 13, 15};
    int r = 0;
    for (int i = 0; i < 9; i++) if (listed[i] <= code) r = i;
    return r;
  endfunction

  int bw_def[4]  = '{15, 8, 5, 2};
  int los_def[4] = '{0, 10, 40, 40};

  bit pin_q[$];
  int e_bw = 2, e_los = 40, e_amp = 0, e_pe = 0, e_dis = 0, e_rng = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pin_q.delete();
      e_bw = 2; e_los = 40; e_amp = 0; e_pe = 0; e_dis = 0; e_rng = 0;
    end else begin
      int s; bit h, l;
      pin_q.push_back(hi); pin_q.push_back(lo);
      if (pin_q.size() >= 6) begin
        h = pin_q[pin_q.size()-6]; l = pin_q[pin_q.size()-5];
      end else begin
        h = 1; l = 0;
      end
      s = slot_of(h, l);
      e_bw  = bwr[s][7]  ? int'(bwr[s][3:0])  : bw_def[s];
      e_los = losr[s][7] ? int'(losr[s][6:0]) : los_def[s];
      case (amp[1:0]) 2'b00: e_amp = 1; 2'b11: e_amp = 4; default: e_amp = 2; endcase
      e_pe  = pe_steps(int'(pe[3:0]));
      e_dis = ctrl[3]; e_rng = ctrl[2];
    end
  end

  always @(negedge clk) begin
    chk("R3 bw_code", bw_code, e_bw);
    chk("R4 los_code", los_code, e_los);
    chk("R5 status", {bw_status, los_status}, {4'b0, 4'(e_bw), 1'b0, 7'(e_los)});
    chk("R7 amp_en", amp_en, e_amp);
    chk("R8 pe_db", pe_db, e_pe);
    chk("R8 pe_therm", pe_therm, (1 << e_pe) - 1);
    chk("R9 ctrl bits", {out_disable, los_high_range}, {1'(e_dis), 1'(e_rng)});
  end

  task automatic step(); @(negedge clk); #2; endtask

  task automatic set_pins(input bit h, input bit l);
    step(); hi = h; lo = l;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    hi = 1'b0; lo = 1'b0;
    bwr[0] = 8'h83; ctrl = 8'h0C; amp = 8'h03; pe = 8'h0F;
    repeat (3) step();
    chk("R10 reset bw", bw_code, 2);
    chk("R10 reset los", los_code, 40);
    chk("R10 reset enables", {amp_en, pe_db, pe_therm, out_disable, los_high_range}, 0);
    rst_n = 1'b1;
    step();
    chk("R2 first cycle slot 3", bw_code, 2);
    step();
    chk("R2 second cycle slot 3", bw_code, 2);
    step();
    chk("R1 slot 0 custom", bw_code, 3);
    bwr = '0; ctrl = '0; amp = '0; pe = '0;
    for (int k = 0; k < 4; k++) begin
      bit h = (k >= 2); bit l = (k == 1 || k == 2);
      set_pins(h, l);
      repeat (3) step();
      chk("R1 default bw by pins", bw_code, bw_def[slot_of(h, l)]);
      chk("R1 default los by pins", los_code, los_def[slot_of(h, l)]);
    end
    for (int s = 0; s < 4; s++) begin
      bwr[s] = 8'h80 | 8'(s + 9); losr[s] = 8'h80 | 8'(s * 30 + 7);
    end
    for (int k = 0; k < 4; k++) begin
      bit h = (k >= 2); bit l = (k == 1 || k == 2);
      set_pins(h, l);
      repeat (3) step();
      chk("R3 custom bw", bw_code, slot_of(h, l) + 9);
      chk("R4 custom los", los_code, slot_of(h, l) * 30 + 7);
    end
    bwr[2] = 8'h7F; losr[2] = 8'h7F;
    set_pins(1, 1); repeat (3) step();
    chk("R3 flag clear ignores low bits", bw_code, 5);
    chk("R4 flag clear ignores low bits", los_code, 40);
    set_pins(0, 1);
    step(); chk("R6 pin latency edge1", bw_code, 5);
    step(); chk("R6 pin latency edge2", bw_code, 5);
    step(); chk("R6 pin latency edge3", bw_code, 10);
    step(); losr[1] = 8'h00; bwr[1] = 8'h81;
    step(); chk("R6 reg latency", bw_code, 1);
    chk("R4 default slot 1", los_code, 10);
    set_pins(1, 0); bwr[3] = 8'h8E;
    step(); bwr[1] = 8'h84;
    step(); chk("R6 old slot new reg", bw_code, 4);
    step(); chk("R1 slot 3 custom", bw_code, 14);
    for (int c = 0; c < 16; c++) begin
      step(); pe = 8'(c); amp = 8'(c % 4); ctrl = 8'(c);
      step();
      chk("R8 pe rounding", pe_db, pe_steps(c));
      chk("R7 amp decode", amp_en, (c % 4 == 0) ? 1 : (c % 4 == 3) ? 4 : 2);
      chk("R9 disable bit", out_disable, (c >> 3) & 1);
    end
    repeat (20) begin
      set_pins(~hi, hi);
      step(); bwr[slot_of(hi, lo)][7] = ~bwr[slot_of(hi, lo)][7];
    end
    repeat (4) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule